// File: doc/BRIEF.md
# Packed BCD Add/Subtract Unit

This block performs arithmetic on two-digit packed decimal bytes with an extend bit carried between bytes. Three operations are offered: add with extend, subtract with extend, and negate with extend, which takes zero minus the operand minus the extend bit. A caller chains multi-byte decimal numbers one byte at a time. Between bytes it feeds the returned extend flag back as `x_in` and the returned zero flag back as `z_in`.

Each operation forms the plain binary sum or difference first. It then applies two decimal corrections, one per digit. Those corrections come from the half-carry or half-borrow and from the binary value itself. The zero flag is accumulative: it can only be cleared, so after a chain it says whether every byte was zero. The overflow flag reports a sign-bit transition that a correction step caused.

Operands are presented with a one-cycle `in_valid` strobe. One clock later, `out_valid` pulses high and the registered result and flags appear. These hold until the next strobe.

Top module: `bcd_arith_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid`, `result` and all five flags read 0 until the first strobe has been registered.
- R2: Operation code: `op` = 2'b00 selects add, 2'b01 selects subtract, and 2'b10 or 2'b11 (bit 1 set) selects negate.
- R3: Add forms the binary value dst + src + x_in. If bit 4 of (dst XOR src XOR value) is 1, or the low nibble of the value is 0xA or more, it adds 0x06. It then adds 0x60 if the running value is 0xA0 or more. `result` is the low 8 bits.
- R4: Subtract forms dst − src − x_in. It subtracts 0x06 if bit 4 of (dst XOR src XOR difference) is 1. It subtracts 0x60 if bit 8 of the uncorrected two's-complement difference is 1. `result` is the low 8 bits.
- R5: Negate behaves as subtract with a destination of zero and `src_opnd` as the operand; `dst_opnd` has no effect on any output.
- R6: `flag_c` and `flag_x` are always equal. They are 1 exactly when the corrected value lies outside 0..255, meaning a decimal carry out for add or a decimal borrow for subtract and negate.
- R7: For add, `flag_v` is 1 if either correction step turns bit 7 from 0 to 1. For subtract and negate, it is 1 if either step turns bit 7 from 1 to 0.
- R8: `flag_z` is 0 when the 8-bit result is nonzero and otherwise equals `z_in`.
- R9: `flag_n` equals bit 7 of `result`.
- R10: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high, so back-to-back strobes give back-to-back results. Without a strobe, `result` and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| op | input | 2 | Operation select (R2) |
| dst_opnd | input | 8 | Destination operand (minuend or addend) |
| src_opnd | input | 8 | Source operand |
| x_in | input | 1 | Extend bit in |
| z_in | input | 1 | Zero flag carried in from the previous byte |
| out_valid | output | 1 | One-cycle result pulse |
| result | output | 8 | Corrected packed BCD byte |
| flag_x | output | 1 | Extend out |
| flag_n | output | 1 | Sign of result |
| flag_z | output | 1 | Accumulative zero |
| flag_v | output | 1 | Correction-induced bit-7 change |
| flag_c | output | 1 | Decimal carry or borrow |

## Verification
The two digit corrections can both fire in one operation, and either can set the overflow flag, so the final flag must be the OR of both steps and must not depend on only the last one. Add is swept over every operand pair with both extend values, which covers every mix of low-only, high-only and double correction. Subtract and negate get random operands plus directed borrow cases. Every strobe is issued back to back, so a new operand set is registered in the same cycle that the previous result is being judged. This exposes any leak between consecutive results.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WIDE_W = BYTE_W + 2;
    localparam int unsigned HALF_B = BYTE_W / 2;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_SUB     = 2'b01,
        OP_NEG     = 2'b10,
        OP_NEG_ALT = 2'b11
    } bcd_op_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] res;
        logic              fx;
        logic              fn;
        logic              fz;
        logic              fv;
        logic              fc;
    } bcd_state_t;
endpackage

// File: rtl/bcd_add_core.sv
module bcd_add_core
    import bcd_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              cin,
    output logic [WIDE_W-1:0] val,
    output logic              ovf
);
    logic [WIDE_W-1:0] raw, step1, step2;
    logic              half_c, lo_fix, hi_fix;

    always_comb begin
        raw    = WIDE_W'(a) + WIDE_W'(b) + WIDE_W'(cin);
        half_c = a[HALF_B] ^ b[HALF_B] ^ raw[HALF_B];
        lo_fix = half_c || (raw[HALF_B-1:0] >= 4'hA);
        step1  = lo_fix ? raw + WIDE_W'('h06) : raw;
        hi_fix = step1 >= WIDE_W'('hA0);
        step2  = hi_fix ? step1 + WIDE_W'('h60) : step1;
        val    = step2;
        ovf    = (lo_fix & ~raw[BYTE_W-1] & step1[BYTE_W-1])
               | (hi_fix & ~step1[BYTE_W-1] & step2[BYTE_W-1]);
    end
endmodule

// File: rtl/bcd_sub_core.sv
module bcd_sub_core
    import bcd_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              bin,
    output logic [WIDE_W-1:0] val,
    output logic              ovf
);
    logic [WIDE_W-1:0] raw, step1, step2;
    logic              lo_fix, hi_fix;

    always_comb begin
        raw    = WIDE_W'(a) - WIDE_W'(b) - WIDE_W'(bin);
        lo_fix = a[HALF_B] ^ b[HALF_B] ^ raw[HALF_B];
        hi_fix = raw[BYTE_W];
        step1  = lo_fix ? raw - WIDE_W'('h06) : raw;
        step2  = hi_fix ? step1 - WIDE_W'('h60) : step1;
        val    = step2;
        ovf    = (lo_fix & raw[BYTE_W-1] & ~step1[BYTE_W-1])
               | (hi_fix & step1[BYTE_W-1] & ~step2[BYTE_W-1]);
    end
endmodule

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit
    import bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] op,
    input  logic [7:0] dst_opnd,
    input  logic [7:0] src_opnd,
    input  logic       x_in,
    input  logic       z_in,
    output logic       out_valid,
    output logic [7:0] result,
    output logic       flag_x,
    output logic       flag_n,
    output logic       flag_z,
    output logic       flag_v,
    output logic       flag_c
);
    bcd_state_t        st_d, st_q;
    logic [WIDE_W-1:0] add_val, sub_val, pick_val;
    logic              add_ovf, sub_ovf, pick_ovf;
    logic [BYTE_W-1:0] minuend_d;
    logic              is_neg_d, is_add_d, carry_d;

    assign is_neg_d  = op[1];
    assign is_add_d  = (op == OP_ADD);
    assign minuend_d = is_neg_d ? '0 : dst_opnd;

    bcd_add_core u_add (
        .a   (dst_opnd),
        .b   (src_opnd),
        .cin (x_in),
        .val (add_val),
        .ovf (add_ovf)
    );

    bcd_sub_core u_sub (
        .a   (minuend_d),
        .b   (src_opnd),
        .bin (x_in),
        .val (sub_val),
        .ovf (sub_ovf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        pick_val = is_add_d ? add_val : sub_val;
        pick_ovf = is_add_d ? add_ovf : sub_ovf;
        carry_d  = |pick_val[WIDE_W-1:BYTE_W];
        if (in_valid) begin
            st_d.res = pick_val[BYTE_W-1:0];
            st_d.fc  = carry_d;
            st_d.fx  = carry_d;
            st_d.fn  = pick_val[BYTE_W-1];
            st_d.fz  = z_in & (pick_val[BYTE_W-1:0] == '0);
            st_d.fv  = pick_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign flag_x    = st_q.fx;
    assign flag_n    = st_q.fn;
    assign flag_z    = st_q.fz;
    assign flag_v    = st_q.fv;
    assign flag_c    = st_q.fc;
endmodule

// File: rtl/bcd_arith_chk.sv
module bcd_arith_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] op,
    input logic [7:0] dst_opnd,
    input logic [7:0] src_opnd,
    input logic       x_in,
    input logic       z_in,
    input logic       out_valid,
    input logic [7:0] result,
    input logic       flag_x,
    input logic       flag_n,
    input logic       flag_z,
    input logic       flag_v,
    input logic       flag_c
);
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_c) && $stable(flag_v)
                       && $stable(flag_z) && $stable(flag_n)));

    p_sticky_z_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !z_in) |=> !flag_z);

    p_nonzero_clears_z_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result != 8'h00) |-> !flag_z);

    p_neg_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[1] && src_opnd == 8'h00 && !x_in)
        |=> (result == 8'h00 && !flag_c && !flag_v));

    p_add_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00 && dst_opnd == 8'h00 && src_opnd == 8'h00 && !x_in)
        |=> (result == 8'h00 && !flag_c && !flag_v));

    p_n_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_n == result[7]));
endmodule

bind bcd_arith_unit bcd_arith_chk u_chk (.*);

// File: tb/bcd_arith_unit_tb_top.sv
`timescale 1ns/1ps
module bcd_arith_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] dst_opnd = 8'h00;
    logic [7:0] src_opnd = 8'h00;
    logic       x_in = 1'b0;
    logic       z_in = 1'b0;
    logic       out_valid;
    logic [7:0] result;
    logic       flag_x, flag_n, flag_z, flag_v, flag_c;

    int   checks = 0;
    int   errors = 0;
    bit   pend = 1'b0;
    bit   done = 1'b0;
    logic [12:0] exp_q = '0;
    logic [1:0]  exp_op = 2'b00;

    always #5 clk = ~clk;

    bcd_arith_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .dst_opnd(dst_opnd), .src_opnd(src_opnd), .x_in(x_in), .z_in(z_in),
        .out_valid(out_valid), .result(result), .flag_x(flag_x),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    // returns {res[7:0], x, n, z, v, c}
    function automatic logic [12:0] ref_bcd(input logic [1:0] o, input int d,
                                            input int s, input int x, input int zi);
        int t, p, dd;
        bit v, c, lo, hi;
        v = 0;
        if (o == 2'b00) begin
            t = d + s + x;
            if ((((d ^ s ^ t) >> 4) & 1) == 1 || (t & 15) >= 10) begin
                p = t; t = t + 6;
                if ((p & 128) == 0 && (t & 128) != 0) v = 1;
            end
            if (t >= 160) begin
                p = t; t = t + 96;
                if ((p & 128) == 0 && (t & 128) != 0) v = 1;
            end
        end else begin
            dd = o[1] ? 0 : d;
            t  = dd - s - x;
            lo = (((dd ^ s ^ t) >> 4) & 1) == 1;
            hi = (t & 256) != 0;
            if (lo) begin
                p = t; t = t - 6;
                if ((p & 128) != 0 && (t & 128) == 0) v = 1;
            end
            if (hi) begin
                p = t; t = t - 96;
                if ((p & 128) != 0 && (t & 128) == 0) v = 1;
            end
        end
        c = (t < 0) || (t > 255);
        ref_bcd = {8'(t & 255), c, 1'((t >> 7) & 1),
                   1'(zi != 0 && (t & 255) == 0), v, c};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic check_pending();
        if (pend) begin
            chk(out_valid == 1'b1, "R10 out_valid", out_valid, 1);
            if (exp_op == 2'b00)
                chk(result == exp_q[12:5], "R3 add result", result, exp_q[12:5]);
            else if (exp_op == 2'b01)
                chk(result == exp_q[12:5], "R4 sub result", result, exp_q[12:5]);
            else
                chk(result == exp_q[12:5], "R5 neg result", result, exp_q[12:5]);
            chk(flag_c == exp_q[0] && flag_x == exp_q[4], "R6 carry/extend",
                {flag_x, flag_c}, {exp_q[4], exp_q[0]});
            chk(flag_v == exp_q[1], "R7 overflow", flag_v, exp_q[1]);
            chk(flag_z == exp_q[2], "R8 zero", flag_z, exp_q[2]);
            chk(flag_n == exp_q[3], "R9 sign", flag_n, exp_q[3]);
        end
    endtask

    task automatic drive(input logic [1:0] o, input int d, input int s,
                         input int x, input int zi);
        @(negedge clk);
        check_pending();
        in_valid = 1'b1; op = o;
        dst_opnd = 8'(d); src_opnd = 8'(s); x_in = 1'(x); z_in = 1'(zi);
        exp_q  = ref_bcd(o, d, s, x, zi);
        exp_op = o;
        pend   = 1'b1;
    endtask

    task automatic idle_and_hold();
        @(negedge clk);
        check_pending();
        in_valid = 1'b0; pend = 1'b0;
        dst_opnd = 8'h5A; src_opnd = 8'hA5; x_in = 1'b1; z_in = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 no pulse without strobe", out_valid, 0);
        chk(result == exp_q[12:5] && flag_z == exp_q[2] && flag_c == exp_q[0],
            "R10 hold", {result, flag_z, flag_c}, {exp_q[12:5], exp_q[2], exp_q[0]});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 32'h00C0FFEE;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && result == 0 && {flag_x, flag_n, flag_z, flag_v, flag_c} == 0,
            "R1 reset state", {out_valid, result}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && result == 0, "R1 after release", {out_valid, result}, 0);

        // directed corners
        drive(2'b00, 'h99, 'h99, 1, 1);   // R3 double correction with carry
        drive(2'b00, 'h00, 'h00, 0, 1);   // R8 zero keeps z_in
        drive(2'b00, 'h00, 'h00, 0, 0);   // R8 zero with z_in low
        drive(2'b01, 'h00, 'h01, 0, 1);   // R4 borrow through both digits
        drive(2'b01, 'h10, 'h0F, 1, 1);   // R4 half-borrow only
        drive(2'b10, 'hFF, 'h00, 1, 1);   // R5 negate of zero with extend
        drive(2'b11, 'h37, 'h01, 0, 1);   // R2 alternate negate code
        idle_and_hold();

        // R3: every add operand pair with both extend values
        for (int d = 0; d < 256; d++)
            for (int s = 0; s < 256; s++)
                for (int x = 0; x < 2; x++)
                    drive(2'b00, d, s, x, int'($urandom % 2));
        idle_and_hold();

        // R5: negate sweep, dst randomised to show it is ignored
        for (int s = 0; s < 256; s++)
            for (int x = 0; x < 2; x++)
                drive(2'b10 | 2'($urandom % 2), int'($urandom % 256), s, x,
                      int'($urandom % 2));

        // R4: random subtract
        for (int i = 0; i < 20000; i++)
            drive(2'b01, int'($urandom % 256), int'($urandom % 256),
                  int'($urandom % 2), int'($urandom % 2));
        idle_and_hold();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule